// File: doc/BRIEF.md
# Dual General-Purpose I/O Port with Per-Bit Inversion

This block provides two 8-bit general-purpose I/O ports. Every port bit has a direction bit, a data bit and an inversion bit. Software reaches all of these through an index/data configuration path. The direction and data registers of both ports can also be reached through a four-byte I/O window whose base address can be moved. Inversion acts on the path from the data register to the pin and also on the path from the pin back to a data read. This lets a board with active-low signals be handled as if its signals were active-high.

The pin drive models an open-drain bus. An output bit whose effective value is 0 pulls the pin low. An output bit whose effective value is 1 releases the pin, so an external pull decides its level. One bit, bit 0 of port 1, is push-pull instead: it drives both levels, because the pin is also sampled as a strap at reset. A port drives nothing unless two conditions hold: its pin group is given to general-purpose use by the pin multiplexer, and the port is enabled either by its own enable bit or by the global enable. The pin inputs arrive already synchronized. Pad electrical behaviour is outside this block.

Top module: `dual_gpio_port`

## Requirements
- R1: After reset every direction register reads FFh, every data and inversion register reads 00h, the control and window-base registers read 00h, no pin is driven (pin_oe = 0, pin_out = 0) and io_hit is 0.
- R2: A direction bit of 0 makes the bit an output and a direction bit of 1 makes it an input. An input bit never has its pin_oe set.
- R3: An inversion bit of 1 inverts the value on both paths: from the data register to the pin, and from the pin to a data read.
- R4: A data read returns the stored data bit for an output bit and (pin_in XOR inversion) for an input bit.
- R5: Every driven output bit other than port 1 bit 0 is open-drain: pin_oe = NOT(data XOR inv) and pin_out = 0.
- R6: Port 1 bit 0 is push-pull: when driven, pin_oe = 1 and pin_out = data XOR inv.
- R7: Control register bit 0 is the global enable, bit 1 enables port 1 and bit 2 enables port 2. A port drives its pins only when its mux_sel bit is 1 (bit 0 for port 1) and either its own enable or the global enable is set. Otherwise its pin_oe and pin_out bits are 0.
- R8: Window offsets map as follows: base+0 is port 1 direction, base+1 is port 1 data, base+2 is port 2 direction and base+3 is port 2 data. Writes there update those registers, and reads return them through the R4 data view.
- R9: The window decodes (io_hit = 1) only when all of these hold: some control enable bit is set, base = {base high, base low} lies in 0100h..0FF8h, base[1:0] = 00, and io_addr[15:2] = base[15:2]. Otherwise io_rdata is 0 and window writes are ignored.
- R10: If the configuration path and the window write the same register in the same cycle, the configuration value is kept. Writes to different registers in the same cycle both take effect.
- R11: A data write to an input bit is stored without changing the pin, and it drives the pin once that bit becomes an output.
- R12: The configuration index map is: 00h control (bits 2:0, upper bits read 0), 01h base high, 02h base low, 10h/11h/12h port 1 direction/data/inversion, and 14h/15h/16h port 2 direction/data/inversion. Other indices read 00h and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_idx | input | 8 | Configuration register index |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_idx |
| io_addr | input | 16 | I/O window address |
| io_we | input | 1 | I/O window write strobe |
| io_wdata | input | 8 | I/O window write data |
| io_hit | output | 1 | io_addr falls inside the active window |
| io_rdata | output | 8 | I/O window read data (0 when no hit) |
| mux_sel | input | 2 | Per-port pin group given to general-purpose use |
| pin_in | input | 16 | Synchronized pin levels, port 1 in bits 7:0 |
| pin_oe | output | 16 | Pin output enable |
| pin_out | output | 16 | Pin output value |

## Verification
Two functions can fall in the same cycle: a configuration-path write and a window write. They may hit the same data or direction register, or different ones. The bench provokes this with directed simultaneous writes to port 1 data, and again with writes to unrelated registers. The random phase issues both strobes together in about a quarter of its cycles, with window addresses placed near the base. A bench model applies the window write first and the configuration write last, so the configuration value wins on a shared target. Every output and read path is then compared against that model after the edge.

// File: rtl/dgp_pkg.sv
// Shared constants for the dual general-purpose I/O port.
// Assumes two ports and a 16-bit I/O address space.
package dgp_pkg;
    localparam int NPORTS  = 2;
    localparam int IO_AW   = 16;
    localparam int CTRL_W  = 3;

    localparam logic [7:0] IDX_CTRL    = 8'h00;
    localparam logic [7:0] IDX_BASE_HI = 8'h01;
    localparam logic [7:0] IDX_BASE_LO = 8'h02;
    localparam logic [7:0] IDX_PORT0   = 8'h10;
    localparam int         IDX_STRIDE  = 4;

    typedef enum logic [1:0] {
        REG_DIR  = 2'd0,
        REG_DATA = 2'd1,
        REG_INV  = 2'd2
    } port_reg_e;

    // Configuration index of one register of one port.
    function automatic logic [7:0] port_idx(input int p, input port_reg_e r);
        return IDX_PORT0 + 8'(p * IDX_STRIDE) + {6'd0, r};
    endfunction
endpackage

// File: rtl/dgp_ctrl_regs.sv
// Holds the enable bits and the window base written over the configuration path.
// Assumes the configuration index decode is exact and writes are single-cycle strobes.
module dgp_ctrl_regs
    import dgp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_idx,
    input  logic [7:0]       cfg_wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [IO_AW-1:0] base_q
);
    logic [7:0] base_hi_q;
    logic [7:0] base_lo_q;

    // Register the enables and both base bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            base_hi_q <= '0;
            base_lo_q <= '0;
        end else if (cfg_we) begin
            if (cfg_idx == IDX_CTRL)    ctrl_q    <= cfg_wdata[CTRL_W-1:0];
            if (cfg_idx == IDX_BASE_HI) base_hi_q <= cfg_wdata;
            if (cfg_idx == IDX_BASE_LO) base_lo_q <= cfg_wdata;
        end
    end

    assign base_q = {base_hi_q, base_lo_q};
endmodule

// File: rtl/dgp_win_dec.sv
// Decodes the four-byte direct I/O window.
// Assumes the base is legal only when aligned to four bytes and inside [WIN_LO, WIN_HI].
module dgp_win_dec #(
    parameter int          AW     = 16,
    parameter logic [15:0] WIN_LO = 16'h0100,
    parameter logic [15:0] WIN_HI = 16'h0FF8
) (
    input  logic [AW-1:0] base,
    input  logic          any_en,
    input  logic [AW-1:0] io_addr,
    output logic          hit,
    output logic [1:0]    off
);
    logic base_ok;

    // Qualify the base, then compare the upper address bits.
    always_comb begin
        base_ok = (base >= AW'(WIN_LO)) && (base <= AW'(WIN_HI)) && (base[1:0] == 2'b00);
        hit     = any_en && base_ok && (io_addr[AW-1:2] == base[AW-1:2]);
        off     = io_addr[1:0];
    end
endmodule

// File: rtl/dgp_port_bank.sv
// One 8-bit port: direction, data and inversion registers plus the pin drive.
// Assumes pin_in is already synchronized. The configuration write wins over a
// window write to the same register. Bits set in PP_MASK are push-pull, the rest open-drain.
module dgp_port_bank #(
    parameter int               PORT_W  = 8,
    parameter logic [PORT_W-1:0] PP_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              cfg_dir_we,
    input  logic              cfg_data_we,
    input  logic              cfg_inv_we,
    input  logic [PORT_W-1:0] cfg_wdata,
    input  logic              win_dir_we,
    input  logic              win_data_we,
    input  logic [PORT_W-1:0] win_wdata,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] dir_q,
    output logic [PORT_W-1:0] data_q,
    output logic [PORT_W-1:0] inv_q,
    output logic [PORT_W-1:0] rd_view,
    output logic [PORT_W-1:0] pin_oe,
    output logic [PORT_W-1:0] pin_out
);
    logic [PORT_W-1:0] drive;
    logic [PORT_W-1:0] eff;

    // Update the port registers, with the configuration path taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '1;
            data_q <= '0;
            inv_q  <= '0;
        end else begin
            if (cfg_dir_we)       dir_q  <= cfg_wdata;
            else if (win_dir_we)  dir_q  <= win_wdata;
            if (cfg_data_we)      data_q <= cfg_wdata;
            else if (win_data_we) data_q <= win_wdata;
            if (cfg_inv_we)       inv_q  <= cfg_wdata;
        end
    end

    // Form the read view and the per-bit drive.
    always_comb begin
        rd_view = (dir_q & (pin_in ^ inv_q)) | (~dir_q & data_q);
        eff     = data_q ^ inv_q;
        drive   = active ? ~dir_q : '0;
        pin_oe  = drive & (PP_MASK | ~eff);
        pin_out = drive & PP_MASK & eff;
    end
endmodule

// File: rtl/dual_gpio_port.sv
// Top of the dual general-purpose I/O port: control registers, window decode,
// two port banks and the read multiplexers.
// Assumes port 1 occupies bits PORT_W-1:0 of the pin vectors, with its bit 0 push-pull.
module dual_gpio_port
    import dgp_pkg::*;
#(
    parameter int          PORT_W = 8,
    parameter logic [15:0] WIN_LO = 16'h0100,
    parameter logic [15:0] WIN_HI = 16'h0FF8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [7:0]               cfg_idx,
    input  logic                     cfg_we,
    input  logic [7:0]               cfg_wdata,
    output logic [7:0]               cfg_rdata,
    input  logic [IO_AW-1:0]         io_addr,
    input  logic                     io_we,
    input  logic [7:0]               io_wdata,
    output logic                     io_hit,
    output logic [7:0]               io_rdata,
    input  logic [NPORTS-1:0]        mux_sel,
    input  logic [NPORTS*PORT_W-1:0] pin_in,
    output logic [NPORTS*PORT_W-1:0] pin_oe,
    output logic [NPORTS*PORT_W-1:0] pin_out
);
    localparam logic [PORT_W-1:0] PP_PORT0 = PORT_W'(1);

    logic [CTRL_W-1:0]       ctrl_q;
    logic [IO_AW-1:0]        base_q;
    logic [1:0]              win_off;
    logic [PORT_W-1:0]       dir_a  [NPORTS];
    logic [PORT_W-1:0]       data_a [NPORTS];
    logic [PORT_W-1:0]       inv_a  [NPORTS];
    logic [PORT_W-1:0]       view_a [NPORTS];
    logic [NPORTS*PORT_W-1:0] data_flat;

    dgp_ctrl_regs u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .ctrl_q    (ctrl_q),
        .base_q    (base_q)
    );

    dgp_win_dec #(.AW(IO_AW), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_dec (
        .base    (base_q),
        .any_en  (|ctrl_q),
        .io_addr (io_addr),
        .hit     (io_hit),
        .off     (win_off)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        localparam logic [1:0] OFF_DIR  = 2'(2 * p);
        localparam logic [1:0] OFF_DATA = 2'(2 * p + 1);
        localparam logic [PORT_W-1:0] PP = (p == 0) ? PP_PORT0 : '0;
        logic act;

        assign act = mux_sel[p] && (ctrl_q[0] || ctrl_q[p+1]);

        dgp_port_bank #(.PORT_W(PORT_W), .PP_MASK(PP)) u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .active      (act),
            .cfg_dir_we  (cfg_we && cfg_idx == port_idx(p, REG_DIR)),
            .cfg_data_we (cfg_we && cfg_idx == port_idx(p, REG_DATA)),
            .cfg_inv_we  (cfg_we && cfg_idx == port_idx(p, REG_INV)),
            .cfg_wdata   (cfg_wdata[PORT_W-1:0]),
            .win_dir_we  (io_we && io_hit && win_off == OFF_DIR),
            .win_data_we (io_we && io_hit && win_off == OFF_DATA),
            .win_wdata   (io_wdata[PORT_W-1:0]),
            .pin_in      (pin_in[p*PORT_W +: PORT_W]),
            .dir_q       (dir_a[p]),
            .data_q      (data_a[p]),
            .inv_q       (inv_a[p]),
            .rd_view     (view_a[p]),
            .pin_oe      (pin_oe[p*PORT_W +: PORT_W]),
            .pin_out     (pin_out[p*PORT_W +: PORT_W])
        );

        assign data_flat[p*PORT_W +: PORT_W] = data_a[p];
    end

    // Configuration read multiplexer.
    always_comb begin
        cfg_rdata = '0;
        if (cfg_idx == IDX_CTRL)    cfg_rdata = 8'(ctrl_q);
        if (cfg_idx == IDX_BASE_HI) cfg_rdata = base_q[15:8];
        if (cfg_idx == IDX_BASE_LO) cfg_rdata = base_q[7:0];
        for (int p = 0; p < NPORTS; p++) begin
            if (cfg_idx == port_idx(p, REG_DIR))  cfg_rdata = 8'(dir_a[p]);
            if (cfg_idx == port_idx(p, REG_DATA)) cfg_rdata = 8'(view_a[p]);
            if (cfg_idx == port_idx(p, REG_INV))  cfg_rdata = 8'(inv_a[p]);
        end
    end

    // Window read multiplexer.
    always_comb begin
        io_rdata = '0;
        if (io_hit) begin
            if (win_off[0]) io_rdata = 8'(view_a[win_off[1]]);
            else            io_rdata = 8'(dir_a[win_off[1]]);
        end
    end
endmodule

// File: rtl/dual_gpio_port_chk.sv
// Checker for dual_gpio_port, attached by bind. It observes ports and the stored data registers.
module dual_gpio_port_chk
    import dgp_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cfg_we,
    input logic [7:0]               cfg_idx,
    input logic [7:0]               cfg_wdata,
    input logic                     io_we,
    input logic [IO_AW-1:0]         io_addr,
    input logic [7:0]               io_wdata,
    input logic                     io_hit,
    input logic [NPORTS-1:0]        mux_sel,
    input logic [NPORTS*PORT_W-1:0] pin_oe,
    input logic [NPORTS*PORT_W-1:0] pin_out,
    input logic [NPORTS*PORT_W-1:0] data_q
);
    localparam logic [NPORTS*PORT_W-1:0] OD_BITS = ~((NPORTS*PORT_W)'(1));

    AST_OPEN_DRAIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & OD_BITS) == '0);  // R5

    AST_P1_UNMUXED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !mux_sel[0] |-> (pin_oe[PORT_W-1:0] == '0 && pin_out[PORT_W-1:0] == '0));  // R7

    AST_P2_UNMUXED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !mux_sel[1] |-> (pin_oe[2*PORT_W-1:PORT_W] == '0 && pin_out[2*PORT_W-1:PORT_W] == '0));  // R7

    AST_HIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        io_hit |-> (io_addr >= 16'h0100 && io_addr <= 16'h0FFB));  // R9

    AST_WIN_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (io_we && io_hit && io_addr[1:0] == 2'd1 && !(cfg_we && cfg_idx == port_idx(0, REG_DATA)))
        |=> data_q[PORT_W-1:0] == $past(io_wdata[PORT_W-1:0]));  // R8

    AST_CFG_WINS_COLLISION: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_idx == port_idx(0, REG_DATA) && io_we && io_hit && io_addr[1:0] == 2'd1)
        |=> data_q[PORT_W-1:0] == $past(cfg_wdata[PORT_W-1:0]));  // R10
endmodule

bind dual_gpio_port dual_gpio_port_chk #(.PORT_W(PORT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_wdata (cfg_wdata),
    .io_we     (io_we),
    .io_addr   (io_addr),
    .io_wdata  (io_wdata),
    .io_hit    (io_hit),
    .mux_sel   (mux_sel),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out),
    .data_q    (data_flat)
);

// File: tb/dual_gpio_port_tb.sv
// Self-checking bench: directed corner cases plus seeded random traffic against a bench model.
module dual_gpio_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_idx = '0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic [15:0] io_addr = '0;
    logic        io_we = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic        io_hit;
    logic [7:0]  io_rdata;
    logic [1:0]  mux_sel = '0;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_oe;
    logic [15:0] pin_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Bench model state.
    logic [2:0]  m_ctrl;
    logic [15:0] m_base;
    logic [7:0]  m_dir  [2];
    logic [7:0]  m_data [2];
    logic [7:0]  m_inv  [2];

    always #2 clk = ~clk;

    dual_gpio_port u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_idx(cfg_idx), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_addr(io_addr),
        .io_we(io_we), .io_wdata(io_wdata), .io_hit(io_hit), .io_rdata(io_rdata),
        .mux_sel(mux_sel), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic m_hit(input logic [15:0] a);
        logic ok;
        ok = (m_base >= 16'h0100) && (m_base <= 16'h0FF8) && (m_base[1:0] == 2'b00);
        return (|m_ctrl) && ok && (a[15:2] == m_base[15:2]);
    endfunction

    function automatic logic [7:0] m_view(input int p);
        logic [7:0] pi;
        pi = pin_in[p*8 +: 8];
        return (m_dir[p] & (pi ^ m_inv[p])) | (~m_dir[p] & m_data[p]);
    endfunction

    function automatic logic [7:0] m_cfg_rd(input logic [7:0] idx);
        case (idx)
            8'h00: return {5'd0, m_ctrl};
            8'h01: return m_base[15:8];
            8'h02: return m_base[7:0];
            8'h10: return m_dir[0];
            8'h11: return m_view(0);
            8'h12: return m_inv[0];
            8'h14: return m_dir[1];
            8'h15: return m_view(1);
            8'h16: return m_inv[1];
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] m_io_rd(input logic [15:0] a);
        if (!m_hit(a)) return 8'h00;
        return a[0] ? m_view(a[1]) : m_dir[a[1]];
    endfunction

    function automatic logic [31:0] m_pins();
        logic [15:0] oe, ou;
        for (int p = 0; p < 2; p++) begin
            logic act;
            logic [7:0] v, drv, pp;
            act = mux_sel[p] && (m_ctrl[0] || m_ctrl[p+1]);
            v   = m_data[p] ^ m_inv[p];
            drv = act ? ~m_dir[p] : 8'h00;
            pp  = (p == 0) ? 8'h01 : 8'h00;
            oe[p*8 +: 8] = drv & (pp | ~v);
            ou[p*8 +: 8] = drv & pp & v;
        end
        return {oe, ou};
    endfunction

    task automatic model_reset();
        m_ctrl = '0;
        m_base = '0;
        for (int p = 0; p < 2; p++) begin
            m_dir[p] = 8'hFF; m_data[p] = 8'h00; m_inv[p] = 8'h00;
        end
    endtask

    // Window write uses pre-edge state; configuration write applied last so it wins.
    task automatic model_apply(input logic cw, input logic [7:0] ci, input logic [7:0] cd,
                               input logic iw, input logic [15:0] ia, input logic [7:0] id);
        if (iw && m_hit(ia)) begin
            if (ia[0]) m_data[ia[1]] = id;
            else       m_dir[ia[1]]  = id;
        end
        if (cw) begin
            case (ci)
                8'h00: m_ctrl = cd[2:0];
                8'h01: m_base[15:8] = cd;
                8'h02: m_base[7:0] = cd;
                8'h10: m_dir[0] = cd;
                8'h11: m_data[0] = cd;
                8'h12: m_inv[0] = cd;
                8'h14: m_dir[1] = cd;
                8'h15: m_data[1] = cd;
                8'h16: m_inv[1] = cd;
                default: ;
            endcase
        end
    endtask

    task automatic step(input logic cw, input logic [7:0] ci, input logic [7:0] cd,
                        input logic iw, input logic [15:0] ia, input logic [7:0] id);
        cfg_we = cw; cfg_idx = ci; cfg_wdata = cd;
        io_we = iw; io_addr = ia; io_wdata = id;
        @(posedge clk);
        model_apply(cw, ci, cd, iw, ia, id);
        #1;
        cfg_we = 1'b0; io_we = 1'b0;
    endtask

    task automatic cfg_wr(input logic [7:0] ci, input logic [7:0] cd);
        step(1'b1, ci, cd, 1'b0, io_addr, 8'h00);
    endtask

    task automatic io_wr(input logic [15:0] ia, input logic [7:0] id);
        step(1'b0, cfg_idx, 8'h00, 1'b1, ia, id);
    endtask

    task automatic cfg_rd_chk(input string tag, input logic [7:0] ci, input logic [7:0] exp);
        cfg_idx = ci;
        #1;
        chk(tag, {8'h00, cfg_rdata}, {8'h00, exp});
    endtask

    task automatic io_rd_chk(input string tag, input logic [15:0] ia, input logic hit_exp,
                             input logic [7:0] exp);
        io_addr = ia;
        #1;
        chk({tag, " hit"}, {15'd0, io_hit}, {15'd0, hit_exp});
        chk(tag, {8'h00, io_rdata}, {8'h00, exp});
    endtask

    task automatic model_chk(input string tag);
        logic [31:0] e;
        #0.5;
        e = m_pins();
        chk({tag, " R5 pin_oe"},  pin_oe,  e[31:16]);
        chk({tag, " R6 pin_out"}, pin_out, e[15:0]);
        chk({tag, " R4 cfg_rdata"}, {8'h00, cfg_rdata}, {8'h00, m_cfg_rd(cfg_idx)});
        chk({tag, " R9 io_hit"},  {15'd0, io_hit}, {15'd0, m_hit(io_addr)});
        chk({tag, " R8 io_rdata"}, {8'h00, io_rdata}, {8'h00, m_io_rd(io_addr)});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] bases [6];
        void'($urandom(32'h5EED_0C17));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        cfg_rd_chk("R1 p1 dir", 8'h10, 8'hFF);
        cfg_rd_chk("R1 p2 dir", 8'h14, 8'hFF);
        cfg_rd_chk("R1 p1 inv", 8'h12, 8'h00);
        cfg_rd_chk("R1 ctrl", 8'h00, 8'h00);
        chk("R1 pin_oe", pin_oe, 16'h0000);
        chk("R1 pin_out", pin_out, 16'h0000);
        io_rd_chk("R1 window", 16'h0000, 1'b0, 8'h00);

        // Enable port 1, base 0200h, pins handed to GPIO.
        mux_sel = 2'b11;
        cfg_wr(8'h00, 8'h02);
        cfg_wr(8'h01, 8'h02);
        cfg_wr(8'h02, 8'h00);

        // R8: window writes
        io_wr(16'h0200, 8'h00);
        cfg_rd_chk("R8 dir via window", 8'h10, 8'h00);
        io_wr(16'h0201, 8'hA5);
        cfg_rd_chk("R8 data via window", 8'h11, 8'hA5);
        io_rd_chk("R8 window read", 16'h0201, 1'b1, 8'hA5);

        // R2 / R5 / R6: open-drain and push-pull drive
        chk("R5 od oe", {8'h00, pin_oe[7:0]}, 16'h005B);
        chk("R6 pp out", {8'h00, pin_out[7:0]}, 16'h0001);
        chk("R2 port2 inputs", {8'h00, pin_oe[15:8]}, 16'h0000);

        // R3: inversion on the output path
        cfg_wr(8'h12, 8'hFF);
        chk("R3 inv oe", {8'h00, pin_oe[7:0]}, 16'h00A5);
        chk("R3 inv out", {8'h00, pin_out[7:0]}, 16'h0000);

        // R3 / R4: inversion on the input path
        io_wr(16'h0200, 8'hFF);
        pin_in[7:0] = 8'h3C;
        io_rd_chk("R3 inv read", 16'h0201, 1'b1, 8'hC3);
        chk("R2 inputs undriven", {8'h00, pin_oe[7:0]}, 16'h0000);

        // R11: stored data on input bits, effective once outputs
        io_wr(16'h0201, 8'h0F);
        chk("R11 no effect while input", {8'h00, pin_oe[7:0]}, 16'h0000);
        io_wr(16'h0200, 8'h00);
        chk("R11 oe after dir", {8'h00, pin_oe[7:0]}, 16'h000F);
        chk("R11 out after dir", {8'h00, pin_out[7:0]}, 16'h0000);

        // R7: pin mux and enables
        mux_sel = 2'b10;
        #1 chk("R7 mux off", {8'h00, pin_oe[7:0]}, 16'h0000);
        mux_sel = 2'b11;
        cfg_wr(8'h14, 8'h00);
        chk("R7 port2 not enabled", {8'h00, pin_oe[15:8]}, 16'h0000);
        cfg_wr(8'h00, 8'h01);
        chk("R7 global enable", {8'h00, pin_oe[15:8]}, 16'h00FF);
        cfg_wr(8'h00, 8'h00);
        chk("R7 all disabled", pin_oe, 16'h0000);

        // R9: decode conditions
        io_rd_chk("R9 disabled", 16'h0201, 1'b0, 8'h00);
        io_wr(16'h0201, 8'h77);
        cfg_rd_chk("R9 write ignored", 8'h11, 8'h0F);
        cfg_wr(8'h00, 8'h04);
        cfg_wr(8'h01, 8'h0F); cfg_wr(8'h02, 8'hF8);
        io_rd_chk("R9 top legal", 16'h0FFB, 1'b1, m_io_rd(16'h0FFB));
        cfg_wr(8'h02, 8'hFC);
        io_rd_chk("R9 above range", 16'h0FFC, 1'b0, 8'h00);
        cfg_wr(8'h01, 8'h00);
        io_rd_chk("R9 below range", 16'h00FC, 1'b0, 8'h00);
        cfg_wr(8'h01, 8'h02); cfg_wr(8'h02, 8'h02);
        io_rd_chk("R9 unaligned", 16'h0202, 1'b0, 8'h00);
        cfg_wr(8'h01, 8'h01); cfg_wr(8'h02, 8'h00);
        io_rd_chk("R9 bottom legal", 16'h0100, 1'b1, 8'h00);

        // R10: simultaneous writes
        step(1'b1, 8'h11, 8'h3C, 1'b1, 16'h0101, 8'hC3);
        cfg_rd_chk("R10 cfg wins", 8'h11, 8'h3C);
        step(1'b1, 8'h16, 8'h55, 1'b1, 16'h0101, 8'h81);
        cfg_rd_chk("R10 both land inv", 8'h16, 8'h55);
        cfg_rd_chk("R10 both land data", 8'h11, 8'h81);

        // R12: unmapped index
        cfg_wr(8'h33, 8'hEE);
        cfg_rd_chk("R12 unmapped", 8'h33, 8'h00);
        cfg_rd_chk("R12 ctrl upper bits", 8'h00, 8'h04);

        // Random phase
        bases[0] = 16'h0100; bases[1] = 16'h0FF8; bases[2] = 16'h0FFC;
        bases[3] = 16'h00FC; bases[4] = 16'h0203; bases[5] = 16'h0A40;
        for (int i = 0; i < 3000; i++) begin
            logic [7:0]  idx_list [10];
            logic [15:0] ia;
            logic        cw, iw;
            logic [7:0]  ci;
            int          r;
            idx_list = '{8'h00, 8'h01, 8'h02, 8'h10, 8'h11, 8'h12, 8'h14, 8'h15, 8'h16, 8'h2A};
            pin_in  = 16'($urandom);
            mux_sel = ($urandom % 8 == 0) ? 2'($urandom) : 2'b11;
            r = $urandom % 100;
            if (r < 3) begin
                logic [15:0] b;
                b = ($urandom % 2) ? bases[$urandom % 6] : {4'h0, 10'($urandom), 2'b00};
                cfg_wr(8'h01, b[15:8]);
                cfg_wr(8'h02, b[7:0]);
            end
            ci = idx_list[3 + $urandom % 7];
            if ($urandom % 10 == 0) ci = 8'h00;
            cw = ($urandom % 2);
            iw = ($urandom % 2);
            ia = m_base + 16'($urandom % 6) - 16'd1;
            step(cw, ci, 8'($urandom), iw, ia, 8'($urandom));
            cfg_idx = idx_list[$urandom % 10];
            io_addr = m_base + 16'($urandom % 6) - 16'd1;
            model_chk("random");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule